// File: doc/BRIEF.md
# Streaming Sliding Bit-Pattern Correlator

This block takes a serial bit stream and tests it against a fixed target pattern of N bits. It tests every bit offset of the stream. The last N accepted bits are held in a shift-register window. A bank of XOR gates compares the whole window with the target in parallel, and the positions that agree are counted. Each time a new bit is accepted and the window holds N bits, the block returns a one-cycle result. The result holds the agreement score, the signed correlation (agreements minus disagreements), and two threshold flags. One flag marks a near or true copy of the pattern. The other marks a near or true copy of its bitwise inverse.

The target and the threshold are plain inputs and are sampled on every clock. A new target therefore applies from the next accepted bit onward. The counting logic can be built as one linear sum or as a set of four-bit group counts followed by a short final sum. Both forms give identical results.

Top module: `bit_correlator`

## Requirements
- R1: While rst is high, and in the first cycle after it is released, out_valid, match_count, corr_value, match_hit and inv_hit are all 0.
- R2: After reset, out_valid stays 0 until N bits have been accepted. From then on it is high for exactly one cycle, the cycle after each accepted bit, and it is 0 otherwise.
- R3: A cycle with in_valid low leaves the window unchanged. Whatever in_bit carries in that cycle has no effect on any later score.
- R4: match_count is the number of positions i where window bit i equals target[i]. Window bit 0 is the newest accepted bit and lines up with target[0]. Window bit N-1 is the oldest bit and lines up with target[N-1].
- R5: With N=5 and target 5'b11010, the stream 1,1,1,0,1,0,0,1,0,1 gives the scores 2,5,2,2,4,0 on its six results.
- R6: corr_value equals 2*match_count - N. It is a two's-complement field one bit wider than match_count, which is ceil(log2(N+1)) bits wide.
- R7: match_hit is 1 exactly when match_count >= threshold.
- R8: inv_hit is 1 exactly when match_count + threshold <= N. A threshold above N therefore never raises it.
- R9: In cycles with out_valid low, match_count and corr_value keep the values of the last result.
- R10: A change of target takes effect in the result of the next accepted bit.
- R11: The grouped counting variant gives the same results as the linear variant for any N, including an N that is not a multiple of four.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Serial data bit |
| in_valid | input | 1 | in_bit is accepted in this cycle |
| target | input | N | Pattern; bit 0 pairs with the newest window bit |
| threshold | input | ceil(log2(N+1)) | Score limit for both flags |
| out_valid | output | 1 | A result is presented this cycle |
| match_count | output | ceil(log2(N+1)) | Number of agreeing positions |
| corr_value | output | ceil(log2(N+1))+1 | Signed 2*match_count - N |
| match_hit | output | 1 | Score at or above threshold |
| inv_hit | output | 1 | Score at or below N - threshold |

## Verification
The bench builds two copies of the block on the same stream. One copy has N=5 with the linear counter. This copy runs the worked example exactly. Its three-bit threshold can also reach 6 and 7, which lie above N, so the range where neither flag may fire is tested. The second copy has N=12 with the grouped counter, which makes three full groups of four. It runs against a bench model on a pseudo-random stream with gaps, so its wider score and correlation fields are checked over many offsets.

// File: rtl/bitcorr_pkg.sv
package bitcorr_pkg;
   typedef enum logic {
      POP_LINEAR  = 1'b0,
      POP_GROUPED = 1'b1
   } pop_style_e;
endpackage

// File: rtl/corr_window.sv
module corr_window #(
   parameter int unsigned N  = 5,
   parameter int unsigned FW = $clog2(N + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_bit,
   input  logic         in_valid,
   output logic [N-1:0] win_next,
   output logic         full_next
);
   localparam logic [FW-1:0] FILL_MAX  = FW'(N);
   localparam logic [FW-1:0] FILL_LAST = FW'(N - 1);

   logic [N-1:0]  win_q;
   logic [FW-1:0] fill_q;

   always_comb begin
      win_next  = in_valid ? {win_q[N-2:0], in_bit} : win_q;
      full_next = in_valid && (fill_q >= FILL_LAST);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         win_q  <= '0;
         fill_q <= '0;
      end else if (in_valid) begin
         win_q <= win_next;
         if (fill_q != FILL_MAX)
            fill_q <= fill_q + 1'b1;
      end
   end

   // R3
   win_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(win_q));

   // R2
   fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
      fill_q <= FILL_MAX);
endmodule

// File: rtl/corr_agree.sv
module corr_agree #(
   parameter int unsigned            N         = 5,
   parameter int unsigned            CW        = $clog2(N + 1),
   parameter bitcorr_pkg::pop_style_e POP_STYLE = bitcorr_pkg::POP_LINEAR
) (
   input  logic [N-1:0]  win,
   input  logic [N-1:0]  target,
   output logic [CW-1:0] agree_cnt
);
   logic [N-1:0] agree;

   // XOR gives 1 on a disagreement; invert to mark agreeing positions
   assign agree = ~(win ^ target);

   generate
      if (POP_STYLE == bitcorr_pkg::POP_LINEAR) begin : g_linear
         always_comb begin
            agree_cnt = '0;
            for (int i = 0; i < N; i++)
               agree_cnt = agree_cnt + CW'(agree[i]);
         end
      end else begin : g_grouped
         localparam int unsigned GRP = 4;
         localparam int unsigned NG  = (N + GRP - 1) / GRP;
         logic [NG*GRP-1:0] agree_pad;
         logic [2:0]        grp_cnt [NG];

         // padding bits are zero, so they add nothing to any group
         assign agree_pad = (NG*GRP)'(agree);

         for (genvar g = 0; g < NG; g++) begin : g_grp
            always_comb begin
               grp_cnt[g] = '0;
               for (int i = 0; i < GRP; i++)
                  grp_cnt[g] = grp_cnt[g] + 3'(agree_pad[g*GRP + i]);
            end
         end

         always_comb begin
            agree_cnt = '0;
            for (int g = 0; g < NG; g++)
               agree_cnt = agree_cnt + CW'(grp_cnt[g]);
         end
      end
   endgenerate
endmodule

// File: rtl/bit_correlator.sv
module bit_correlator #(
   parameter int unsigned             N         = 5,
   parameter bitcorr_pkg::pop_style_e POP_STYLE = bitcorr_pkg::POP_LINEAR,
   localparam int unsigned            CW        = $clog2(N + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_bit,
   input  logic                 in_valid,
   input  logic [N-1:0]         target,
   input  logic [CW-1:0]        threshold,
   output logic                 out_valid,
   output logic [CW-1:0]        match_count,
   output logic signed [CW:0]   corr_value,
   output logic                 match_hit,
   output logic                 inv_hit
);
   generate
      if (N < 2) begin : g_bad_n
         $error("bit_correlator: N must be at least 2");
      end
   endgenerate

   logic [N-1:0]  win_next;
   logic          full_next;
   logic [CW-1:0] agree_cnt;
   logic [CW:0]   twice_cnt;
   logic [CW:0]   corr_next;
   logic [CW:0]   flag_sum;
   logic          hit_m_next;
   logic          hit_i_next;

   corr_window #(.N(N), .FW(CW)) u_window (
      .clk       (clk),
      .rst       (rst),
      .in_bit    (in_bit),
      .in_valid  (in_valid),
      .win_next  (win_next),
      .full_next (full_next)
   );

   corr_agree #(.N(N), .CW(CW), .POP_STYLE(POP_STYLE)) u_agree (
      .win       (win_next),
      .target    (target),
      .agree_cnt (agree_cnt)
   );

   always_comb begin
      twice_cnt  = {agree_cnt, 1'b0};
      corr_next  = twice_cnt - (CW+1)'(N);
      flag_sum   = {1'b0, agree_cnt} + {1'b0, threshold};
      hit_m_next = agree_cnt >= threshold;
      hit_i_next = flag_sum <= (CW+1)'(N);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid   <= 1'b0;
         match_count <= '0;
         corr_value  <= '0;
         match_hit   <= 1'b0;
         inv_hit     <= 1'b0;
      end else begin
         out_valid <= full_next;
         if (full_next) begin
            match_count <= agree_cnt;
            corr_value  <= corr_next;
            match_hit   <= hit_m_next;
            inv_hit     <= hit_i_next;
         end
      end
   end

   // R2
   valid_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   // R9
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> ($stable(match_count) && $stable(corr_value)));

   // R6
   corr_sign_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((corr_value < 0) == ((2 * match_count) < N)));

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (match_count <= N));
endmodule

// File: tb/bit_correlator_bench.sv
`timescale 1ns/1ps
module bit_correlator_bench;
   localparam int NA = 5;
   localparam int NB = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_bit = 1'b0;
   logic in_valid = 1'b0;

   logic [NA-1:0]     tgt_a = '0;
   logic [2:0]        thr_a = 3'd5;
   logic              ov_a, mh_a, ih_a;
   logic [2:0]        mc_a;
   logic signed [3:0] cv_a;

   logic [NB-1:0]     tgt_b = 12'hA5C;
   logic [3:0]        thr_b = 4'd9;
   logic              ov_b, mh_b, ih_b;
   logic [3:0]        mc_b;
   logic signed [4:0] cv_b;

   int n_chk = 0;
   int n_fail = 0;

   logic [NA-1:0] h_a;
   logic [NB-1:0] h_b;
   int f_a, f_b, prev_m_a, prev_c_a;
   int last_m_a;

   always #5 clk = ~clk;

   bit_correlator #(.N(NA), .POP_STYLE(bitcorr_pkg::POP_LINEAR)) u_bit_correlator (
      .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
      .target(tgt_a), .threshold(thr_a), .out_valid(ov_a),
      .match_count(mc_a), .corr_value(cv_a), .match_hit(mh_a), .inv_hit(ih_a));

   bit_correlator #(.N(NB), .POP_STYLE(bitcorr_pkg::POP_GROUPED)) u_bit_correlator_wide (
      .clk(clk), .rst(rst), .in_bit(in_bit), .in_valid(in_valid),
      .target(tgt_b), .threshold(thr_b), .out_valid(ov_b),
      .match_count(mc_b), .corr_value(cv_b), .match_hit(mh_b), .inv_hit(ih_b));

   function automatic int agree_count(logic [63:0] h, logic [63:0] t, int n);
      int c = 0;
      for (int i = 0; i < n; i++) if (h[i] == t[i]) c++;
      return c;
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one cycle: drive at negedge, release in_valid after the edge, sample at next negedge
   task automatic step(logic b, logic v);
      int m;
      in_bit = b;
      in_valid = v;
      @(posedge clk);
      #1 in_valid = 1'b0;
      @(negedge clk);
      if (v) begin
         h_a = {h_a[NA-2:0], b};
         h_b = {h_b[NB-2:0], b};
         if (f_a < NA) f_a++;
         if (f_b < NB) f_b++;
      end
      check(ov_a == (v && f_a >= NA), "R2 out_valid", int'(ov_a), int'(v && f_a >= NA));
      if (v && f_a >= NA) begin
         m = agree_count(64'(h_a), 64'(tgt_a), NA);
         last_m_a = m;
         check(int'(mc_a) == m, "R4 match_count", int'(mc_a), m);
         check(int'(cv_a) == 2*m - NA, "R6 corr_value", int'(cv_a), 2*m - NA);
         check(mh_a == (m >= int'(thr_a)), "R7 match_hit", int'(mh_a), int'(m >= int'(thr_a)));
         check(ih_a == (m + int'(thr_a) <= NA), "R8 inv_hit", int'(ih_a), int'(m + int'(thr_a) <= NA));
         prev_m_a = m;
         prev_c_a = 2*m - NA;
      end else begin
         check(int'(mc_a) == prev_m_a, "R9 match_count hold", int'(mc_a), prev_m_a);
         check(int'(cv_a) == prev_c_a, "R9 corr_value hold", int'(cv_a), prev_c_a);
      end
      check(ov_b == (v && f_b >= NB), "R11 out_valid wide", int'(ov_b), int'(v && f_b >= NB));
      if (v && f_b >= NB) begin
         m = agree_count(64'(h_b), 64'(tgt_b), NB);
         check(int'(mc_b) == m, "R11 match_count wide", int'(mc_b), m);
         check(int'(cv_b) == 2*m - NB, "R11 corr_value wide", int'(cv_b), 2*m - NB);
         check(mh_b == (m >= int'(thr_b)), "R11 match_hit wide", int'(mh_b), int'(m >= int'(thr_b)));
         check(ih_b == (m + int'(thr_b) <= NB), "R11 inv_hit wide", int'(ih_b), int'(m + int'(thr_b) <= NB));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(ov_a == 1'b0 && ov_b == 1'b0, "R1 out_valid in reset", int'(ov_a), 0);
      rst = 1'b0;
      @(negedge clk);
      h_a = '0; h_b = '0; f_a = 0; f_b = 0;
      prev_m_a = 0; prev_c_a = 0;
      check(ov_a == 1'b0, "R1 out_valid", int'(ov_a), 0);
      check(mc_a == '0 && mc_b == '0, "R1 match_count", int'(mc_a), 0);
      check(cv_a == '0 && cv_b == '0, "R1 corr_value", int'(cv_a), 0);
      check({mh_a, ih_a, mh_b, ih_b} == 4'b0, "R1 flags", int'({mh_a, ih_a}), 0);
   endtask

   task automatic t_example();
      logic [9:0] data = 10'b1110100101;
      int ex [6] = '{2, 5, 2, 2, 4, 0};
      t_reset();
      tgt_a = 5'b11010;
      thr_a = 3'd5;
      for (int k = 0; k < 10; k++) begin
         step(data[9-k], 1'b1);
         if (k >= NA - 1)
            check(int'(mc_a) == ex[k-(NA-1)], "R5 example score", int'(mc_a), ex[k-(NA-1)]);
      end
      check(cv_a == -4'sd5, "R5 inverse gives corr -N", int'(cv_a), -5);
   endtask

   task automatic t_gaps();
      int m;
      tgt_a = 5'b10011;
      thr_a = 3'd4;
      for (int k = 0; k < 12; k++) begin
         step(k[0] ^ k[2], 1'b1);
         step(~(k[0] ^ k[2]), 1'b0);
         step(1'b1, 1'b0);
         m = agree_count(64'(h_a), 64'(tgt_a), NA);
         check(int'(mc_a) == m, "R3 ignored bits leave score", int'(mc_a), m);
      end
   endtask

   task automatic t_thresholds();
      for (int t = 0; t < 8; t++) begin
         thr_a = 3'(t);
         for (int k = 0; k < 4; k++) step(k[0] ^ t[1], 1'b1);
      end
      thr_a = 3'd6;
      tgt_a = 5'b00000;
      for (int k = 0; k < NA; k++) step(1'b1, 1'b1);
      check(mc_a == 3'd0 && ih_a == 1'b0, "R8 threshold above N no inv_hit", int'(ih_a), 0);
      check(mh_a == 1'b0, "R7 threshold above N no match_hit", int'(mh_a), 0);
      thr_a = 3'd0;
      step(1'b1, 1'b1);
      check(mh_a == 1'b1 && ih_a == 1'b1, "R7 threshold zero both flags", int'({mh_a, ih_a}), 3);
   endtask

   task automatic t_target_change();
      int m;
      thr_a = 3'd5;
      tgt_a = 5'b01101;
      for (int k = 0; k < NA; k++) step(tgt_a[NA-1-k], 1'b1);
      check(mc_a == 3'd5 && mh_a, "R10 exact match before change", int'(mc_a), 5);
      tgt_a = ~tgt_a;
      step(1'b0, 1'b0);
      check(mc_a == 3'd5, "R10 no result without accepted bit", int'(mc_a), 5);
      step(1'b1, 1'b1);
      m = agree_count(64'(h_a), 64'(tgt_a), NA);
      check(int'(mc_a) == m, "R10 new target applied", int'(mc_a), m);
   endtask

   task automatic t_random();
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (k % 37 == 0) begin
            thr_b = lf[3:0];
            thr_a = lf[6:4];
            tgt_a = lf[11:7];
         end
         step(lf[0], lf[1] | lf[2]);
      end
      check(last_m_a <= NA, "R4 score bound", last_m_a, NA);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_example();
      t_gaps();
      t_thresholds();
      t_target_change();
      t_random();
      t_reset();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule